// File: doc/BRIEF.md
# SENT Sensor Frame Transmitter

This block sends a dual-channel sensor's readings as SENT frames on a single line. The line is only ever pulled low or released, and an enable output shows when the output stage is switched on. A tick generator cuts the unit time out of the system clock using a 4-bit divider setting. On every frame boundary the sequencer captures both measurement channels, or one channel and the temperature code, along with a status nibble. It then plays out a sync pulse, the status nibble, six data nibbles and a CRC nibble, with each nibble coded as a pulse length.

The status nibble reports three things: the selected magnetic range, a warning that the supply went over voltage, and a marker for the first frame after reset. A startup phase or an over-voltage condition switches the output stage off for as long as it lasts. A memory failure switches the output stage off until the next reset. The temperature code is the junction temperature in degrees Celsius plus 55, so the codes 0 to 255 cover -55 to 200 degrees.

Top module: `sent_tx`

## Requirements
- R1: One tick lasts 2*D+2 clock cycles, where D is the effective divider setting. Writing `cfg_prediv` with `cfg_we` high changes the setting, and a setting of 15 gives 32 cycles per tick.
- R2: Divider settings below 7 act as 7, giving 16 cycles per tick. After reset the setting is 11, giving 24 cycles per tick.
- R3: A frame is a 56-tick sync pulse followed by eight nibbles, and each nibble lasts 12+value ticks. Every pulse begins with exactly 5 ticks of `line_out` low, and the line is released (1) for the rest of the pulse. Frames follow each other with no gap.
- R4: The six data nibbles, in order, are `meas_a[11:8]`, `meas_a[7:4]`, `meas_a[3:0]`, then the same three slices of channel B. Channel B is `meas_b`, or `{4'h0, temp_code}` when `temp_sel` is 1.
- R5: Status nibble bits [1:0] carry `range_sel`.
- R6: Status bit 3 is 1 in the first frame completed after reset and 0 in every later frame.
- R7: While `startup` or `over_volt` is 1, `drive_en` is 0 and `line_out` is 1, and any frame in progress is abandoned. Status bit 2 is 1 in the first frame completed after `over_volt` has been seen, and 0 after that.
- R8: Once `mem_fail` has been 1 for a cycle, `drive_en` stays 0 and `line_out` stays 1 until reset, whatever `mem_fail` does afterwards.
- R9: The CRC nibble is computed over the six data nibbles only. It starts from 4'b0101 and shifts each nibble in MSB first with polynomial x^4+x^3+x^2+1. Per bit: feedback = crc[3] xor bit, shift crc left, and XOR with 4'b1101 if feedback is 1.
- R10: Inputs are captured when a sync pulse starts, so changing them during a frame does not alter that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Unit clock (8 MHz nominal) |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Write strobe for the divider setting |
| cfg_prediv | input | 4 | New divider setting |
| meas_a | input | 12 | Channel A measurement |
| meas_b | input | 12 | Channel B measurement |
| temp_code | input | 8 | Junction temperature plus 55 |
| temp_sel | input | 1 | 1: send temperature in place of channel B |
| range_sel | input | 2 | Selected magnetic range code |
| startup | input | 1 | Startup phase active |
| over_volt | input | 1 | Supply over-voltage present |
| mem_fail | input | 1 | Uncorrectable memory failure |
| line_out | output | 1 | Line level: 0 pulls low, 1 releases |
| drive_en | output | 1 | Output stage enabled |

## Verification
The bench uses the default parameters: 12-bit channels, an 8-bit temperature, a 56-tick sync and a 4-bit divider. Because the divider can be rewritten at run time, frames are checked at 16, 24 and 32 cycles per tick. This covers the clamp for settings below 7, the reset setting of 11 and the top setting of 15. The receiver in the bench identifies the sync pulse from the interval between falling edges and decodes nibbles from pulse lengths. With this it can check the status flags across the first frame, an over-voltage window and a memory-failure lockout, and also check that inputs changed in the middle of a frame do not reach that frame.

// File: rtl/sent_pkg.sv
package sent_pkg;
  localparam int NIB_W = 4;
  localparam logic [3:0] CRC_SEED = 4'b0101;
  localparam logic [3:0] CRC_POLY = 4'b1101;

  // Shift one nibble into the running checksum, MSB first.
  function automatic logic [3:0] crc4_step(input logic [3:0] c, input logic [3:0] n);
    logic [3:0] r;
    logic fb;
    r = c;
    for (int b = 3; b >= 0; b--) begin
      fb = r[3] ^ n[b];
      r  = {r[2:0], 1'b0};
      if (fb) r = r ^ CRC_POLY;
    end
    return r;
  endfunction
endpackage

// File: rtl/sent_tick_gen.sv
module sent_tick_gen #(
  parameter int PW   = 4,
  parameter int PMIN = 7,
  parameter int PRST = 11
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_we,
  input  logic [PW-1:0] cfg_prediv,
  output logic          tick
);
  localparam int CW = PW + 1;

  logic [PW-1:0] prediv_q;
  logic [PW-1:0] eff;
  logic [CW-1:0] lim;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) prediv_q <= PRST[PW-1:0];
    else if (cfg_we) prediv_q <= cfg_prediv;
  end

  // Settings under the floor are raised to it.
  always_comb begin
    eff = (prediv_q < PMIN[PW-1:0]) ? PMIN[PW-1:0] : prediv_q;
    lim = {eff, 1'b1};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt >= lim) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + 1'b1;
      tick <= 1'b0;
    end
  end

  AST_TICK_SPACING: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick); // R1
endmodule

// File: rtl/sent_frame_seq.sv
module sent_frame_seq
  import sent_pkg::*;
#(
  parameter int DATA_NIBS  = 6,
  parameter int SYNC_TICKS = 56,
  parameter int LOW_TICKS  = 5,
  parameter int NIB_BASE   = 12
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       tick,
  input  logic                       run,
  input  logic [NIB_W-1:0]           status_in,
  input  logic [DATA_NIBS*NIB_W-1:0] data_in,
  output logic                       low,
  output logic                       wrap
);
  localparam int SEGS   = DATA_NIBS + 3;
  localparam int STORED = SEGS - 1;
  localparam int LAST   = SEGS - 1;
  localparam int SW     = $clog2(SEGS);
  localparam int MAXLEN = (SYNC_TICKS > NIB_BASE + 15) ? SYNC_TICKS : NIB_BASE + 15;
  localparam int TW     = $clog2(MAXLEN + 1);

  logic                         active;
  logic [SW-1:0]                seg;
  logic [TW-1:0]                tcnt;
  logic [STORED-1:0][NIB_W-1:0] nib_q;
  logic [STORED-1:0][NIB_W-1:0] frame_c;
  logic [NIB_W-1:0]             crc_c;
  logic [NIB_W-1:0]             cur;
  logic [TW-1:0]                len;
  logic                         tcnt_end;
  logic                         wrap_end;
  logic                         load;

  always_comb begin
    crc_c = CRC_SEED;
    for (int i = 0; i < DATA_NIBS; i++)
      crc_c = crc4_step(crc_c, data_in[(DATA_NIBS-1-i)*NIB_W +: NIB_W]);
    frame_c[0] = status_in;
    for (int i = 0; i < DATA_NIBS; i++)
      frame_c[i+1] = data_in[(DATA_NIBS-1-i)*NIB_W +: NIB_W];
    frame_c[STORED-1] = crc_c;
  end

  always_comb begin
    cur = '0;
    for (int i = 0; i < STORED; i++)
      if (seg == SW'(i + 1)) cur = nib_q[i];
    len      = (seg == '0) ? TW'(SYNC_TICKS) : TW'(NIB_BASE) + TW'(cur);
    tcnt_end = (tcnt == len - TW'(1));
    wrap_end = (seg == SW'(LAST)) && tcnt_end;
    load     = run && tick && (!active || wrap_end);
    wrap     = run && tick && active && wrap_end;
    low      = active && (tcnt < TW'(LOW_TICKS));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      seg    <= '0;
      tcnt   <= '0;
      nib_q  <= '0;
    end else if (!run) begin
      active <= 1'b0;
      seg    <= '0;
      tcnt   <= '0;
    end else if (tick) begin
      if (!active || wrap_end) begin
        active <= 1'b1;
        seg    <= '0;
        tcnt   <= '0;
        nib_q  <= frame_c;
      end else if (tcnt_end) begin
        seg  <= seg + 1'b1;
        tcnt <= '0;
      end else begin
        tcnt <= tcnt + 1'b1;
      end
    end
  end

  AST_PULSE_STARTS_LOW: assert property (@(posedge clk) disable iff (rst)
    (run && tick && (!active || tcnt_end)) |=> low); // R3
  AST_FRAME_HELD: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(nib_q)); // R10
endmodule

// File: rtl/sent_tx.sv
module sent_tx
  import sent_pkg::*;
#(
  parameter int DATA_W     = 12,
  parameter int TEMP_W     = 8,
  parameter int PREDIV_W   = 4,
  parameter int PREDIV_MIN = 7,
  parameter int PREDIV_RST = 11,
  parameter int SYNC_TICKS = 56,
  parameter int LOW_TICKS  = 5,
  parameter int NIB_BASE   = 12
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cfg_we,
  input  logic [PREDIV_W-1:0] cfg_prediv,
  input  logic [DATA_W-1:0]   meas_a,
  input  logic [DATA_W-1:0]   meas_b,
  input  logic [TEMP_W-1:0]   temp_code,
  input  logic                temp_sel,
  input  logic [1:0]          range_sel,
  input  logic                startup,
  input  logic                over_volt,
  input  logic                mem_fail,
  output logic                line_out,
  output logic                drive_en
);
  localparam int DATA_NIBS = 2 * DATA_W / NIB_W;

  logic                       tick;
  logic                       run;
  logic                       low;
  logic                       wrap;
  logic                       memfail_q;
  logic                       first_q;
  logic                       ovp_q;
  logic [DATA_W-1:0]          chan_b;
  logic [NIB_W-1:0]           status_c;
  logic [DATA_NIBS*NIB_W-1:0] data_c;

  sent_tick_gen #(
    .PW  (PREDIV_W),
    .PMIN(PREDIV_MIN),
    .PRST(PREDIV_RST)
  ) u_tick (
    .clk       (clk),
    .rst       (rst),
    .cfg_we    (cfg_we),
    .cfg_prediv(cfg_prediv),
    .tick      (tick)
  );

  always_comb begin
    run      = !(startup || over_volt || mem_fail || memfail_q);
    chan_b   = temp_sel ? DATA_W'(temp_code) : meas_b;
    data_c   = {meas_a, chan_b};
    // A flag leaves the next frame's status once the frame carrying it ends.
    status_c = {first_q & ~wrap, ovp_q & ~wrap, range_sel};
  end

  sent_frame_seq #(
    .DATA_NIBS (DATA_NIBS),
    .SYNC_TICKS(SYNC_TICKS),
    .LOW_TICKS (LOW_TICKS),
    .NIB_BASE  (NIB_BASE)
  ) u_seq (
    .clk      (clk),
    .rst      (rst),
    .tick     (tick),
    .run      (run),
    .status_in(status_c),
    .data_in  (data_c),
    .low      (low),
    .wrap     (wrap)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      memfail_q <= 1'b0;
      first_q   <= 1'b1;
      ovp_q     <= 1'b0;
    end else begin
      if (mem_fail) memfail_q <= 1'b1;
      if (wrap) first_q <= 1'b0;
      if (over_volt) ovp_q <= 1'b1;
      else if (wrap) ovp_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      line_out <= 1'b1;
      drive_en <= 1'b0;
    end else begin
      line_out <= !(run && low);
      drive_en <= run;
    end
  end

  AST_FAULT_OFF: assert property (@(posedge clk) disable iff (rst)
    (startup || over_volt) |=> !drive_en); // R7
  AST_OFF_RELEASED: assert property (@(posedge clk) disable iff (rst)
    !drive_en |-> line_out); // R7
  AST_MEM_LOCK: assert property (@(posedge clk) disable iff (rst)
    (mem_fail || memfail_q) |=> !drive_en); // R8
endmodule

// File: tb/sim_sent_tx.sv
module sim_sent_tx;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_prediv = 4'd0;
  logic [11:0] meas_a = 12'h0;
  logic [11:0] meas_b = 12'h0;
  logic [7:0]  temp_code = 8'h0;
  logic        temp_sel = 1'b0;
  logic [1:0]  range_sel = 2'b00;
  logic        startup = 1'b1;
  logic        over_volt = 1'b0;
  logic        mem_fail = 1'b0;
  logic        line_out;
  logic        drive_en;

  int checks = 0;
  int errors = 0;
  bit prev_line = 1'b1;
  bit aligned = 1'b0;

  always #4 clk = ~clk;

  sent_tx u0 (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_prediv(cfg_prediv),
    .meas_a(meas_a), .meas_b(meas_b), .temp_code(temp_code), .temp_sel(temp_sel),
    .range_sel(range_sel), .startup(startup), .over_volt(over_volt),
    .mem_fail(mem_fail), .line_out(line_out), .drive_en(drive_en)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] ref_crc(input logic [23:0] d);
    logic [3:0] c;
    logic [3:0] n;
    logic fb;
    c = 4'b0101;
    for (int i = 0; i < 6; i++) begin
      n = d[23-4*i -: 4];
      for (int b = 3; b >= 0; b--) begin
        fb = c[3] ^ n[b];
        c = {c[2:0], 1'b0};
        if (fb) c = c ^ 4'b1101;
      end
    end
    return c;
  endfunction

  function automatic logic [31:0] ref_frame(input logic [3:0] st, input logic [11:0] a,
                                            input logic [11:0] b);
    return {st, a, b, ref_crc({a, b})};
  endfunction

  task automatic wait_fall();
    prev_line = line_out;
    forever begin
      @(negedge clk);
      if (prev_line && !line_out) begin
        prev_line = 1'b0;
        break;
      end
      prev_line = line_out;
    end
  endtask

  task automatic next_fall(output int cyc, output int lowc);
    cyc = 1;
    lowc = 1;
    forever begin
      @(negedge clk);
      if (prev_line && !line_out) begin
        prev_line = 1'b0;
        break;
      end
      cyc++;
      if (!line_out) lowc++;
      prev_line = line_out;
    end
  endtask

  // Finds a sync pulse of the given tick size and decodes the eight nibbles after it.
  task automatic get_frame(input int cpt, input bit swap, input logic [11:0] new_a,
                           output logic [31:0] fr, output bit found, output bit low_ok);
    int cyc;
    int lc;
    fr = '0;
    found = 1'b0;
    low_ok = 1'b1;
    if (!aligned) wait_fall();
    for (int k = 0; k < 40; k++) begin
      next_fall(cyc, lc);
      if (cyc == 56 * cpt) begin
        found = 1'b1;
        break;
      end
    end
    if (!found) begin
      aligned = 1'b0;
      return;
    end
    if (lc != 5 * cpt) low_ok = 1'b0;
    if (swap) meas_a = new_a;
    for (int i = 0; i < 8; i++) begin
      next_fall(cyc, lc);
      if ((cyc % cpt) != 0 || lc != 5 * cpt) low_ok = 1'b0;
      fr[31-4*i -: 4] = 4'(cyc / cpt - 12);
    end
    aligned = 1'b1;
  endtask

  task automatic write_prediv(input logic [3:0] v);
    @(negedge clk);
    cfg_prediv = v;
    cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
    aligned = 1'b0;
  endtask

  task automatic t_reset();
    repeat (5) @(posedge clk);
    @(negedge clk);
    chk(drive_en == 1'b0 && line_out == 1'b1, "R7 reset state", {drive_en, line_out}, 2'b01);
    rst = 1'b0;
    repeat (60) @(negedge clk);
    chk(drive_en == 1'b0 && line_out == 1'b1, "R7 held off in startup", {drive_en, line_out}, 2'b01);
  endtask

  task automatic t_first_frames();
    logic [31:0] fr;
    bit f;
    bit lo;
    meas_a = 12'hA5C;
    meas_b = 12'h3F0;
    range_sel = 2'b10;
    @(negedge clk);
    startup = 1'b0;
    aligned = 1'b0;
    get_frame(24, 1'b0, 12'h0, fr, f, lo);
    chk(f, "R2 reset divider gives 24-cycle ticks", f, 1);
    chk(lo, "R3 pulse shapes", lo, 1);
    chk(fr[31:28] == 4'b1010, "R6 first frame status", fr[31:28], 4'b1010);
    chk(fr[27:4] == {12'hA5C, 12'h3F0}, "R4 data nibbles", fr[27:4], {12'hA5C, 12'h3F0});
    chk(fr[3:0] == ref_crc({12'hA5C, 12'h3F0}), "R9 crc", fr[3:0], ref_crc({12'hA5C, 12'h3F0}));
    get_frame(24, 1'b0, 12'h0, fr, f, lo);
    chk(fr == ref_frame(4'b0010, 12'hA5C, 12'h3F0), "R6 later frame clears first flag",
        fr, ref_frame(4'b0010, 12'hA5C, 12'h3F0));
  endtask

  task automatic t_divider();
    logic [31:0] fr;
    bit f;
    bit lo;
    write_prediv(4'd3);
    get_frame(16, 1'b0, 12'h0, fr, f, lo);
    chk(f && lo, "R2 setting 3 clamped to 16-cycle ticks", {f, lo}, 2'b11);
    write_prediv(4'd15);
    get_frame(32, 1'b0, 12'h0, fr, f, lo);
    chk(f && lo, "R1 setting 15 gives 32-cycle ticks", {f, lo}, 2'b11);
    chk(fr == ref_frame(4'b0010, 12'hA5C, 12'h3F0), "R1 frame intact at slow ticks",
        fr, ref_frame(4'b0010, 12'hA5C, 12'h3F0));
    write_prediv(4'd7);
    get_frame(16, 1'b0, 12'h0, fr, f, lo);
    chk(f, "R1 setting 7 gives 16-cycle ticks", f, 1);
  endtask

  task automatic t_temp_mode();
    logic [31:0] fr;
    bit f;
    bit lo;
    temp_sel = 1'b1;
    temp_code = 8'hD2;
    range_sel = 2'b01;
    meas_a = 12'h00F;
    get_frame(16, 1'b0, 12'h0, fr, f, lo);
    get_frame(16, 1'b0, 12'h0, fr, f, lo);
    chk(fr == ref_frame(4'b0001, 12'h00F, 12'h0D2), "R4 temperature replaces channel B",
        fr, ref_frame(4'b0001, 12'h00F, 12'h0D2));
    chk(fr[29:28] == 2'b01, "R5 range bits", fr[29:28], 2'b01);
    temp_sel = 1'b0;
  endtask

  task automatic t_capture();
    logic [31:0] fr;
    bit f;
    bit lo;
    meas_a = 12'h111;
    meas_b = 12'h9C3;
    range_sel = 2'b11;
    get_frame(16, 1'b0, 12'h0, fr, f, lo);
    get_frame(16, 1'b1, 12'hEEE, fr, f, lo);
    chk(fr == ref_frame(4'b0011, 12'h111, 12'h9C3), "R10 mid-frame change ignored",
        fr, ref_frame(4'b0011, 12'h111, 12'h9C3));
    get_frame(16, 1'b0, 12'h0, fr, f, lo);
    chk(fr == ref_frame(4'b0011, 12'hEEE, 12'h9C3), "R10 change taken next frame",
        fr, ref_frame(4'b0011, 12'hEEE, 12'h9C3));
  endtask

  task automatic t_overvolt();
    logic [31:0] fr;
    bit f;
    bit lo;
    repeat (300) @(negedge clk);
    over_volt = 1'b1;
    repeat (3) @(negedge clk);
    chk(drive_en == 1'b0 && line_out == 1'b1, "R7 over-voltage disables", {drive_en, line_out}, 2'b01);
    repeat (400) @(negedge clk);
    chk(drive_en == 1'b0 && line_out == 1'b1, "R7 stays off", {drive_en, line_out}, 2'b01);
    over_volt = 1'b0;
    aligned = 1'b0;
    get_frame(16, 1'b0, 12'h0, fr, f, lo);
    chk(f && fr[31:28] == 4'b0111, "R7 warning bit in first frame after", fr[31:28], 4'b0111);
    get_frame(16, 1'b0, 12'h0, fr, f, lo);
    chk(fr[31:28] == 4'b0011, "R7 warning bit cleared afterwards", fr[31:28], 4'b0011);
  endtask

  task automatic t_memfail();
    logic [31:0] fr;
    bit f;
    bit lo;
    int bad;
    bad = 0;
    mem_fail = 1'b1;
    repeat (5) @(negedge clk);
    mem_fail = 1'b0;
    for (int i = 0; i < 6000; i++) begin
      @(negedge clk);
      if (drive_en || !line_out) bad++;
    end
    chk(bad == 0, "R8 lockout after memory failure", bad, 0);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    aligned = 1'b0;
    get_frame(24, 1'b0, 12'h0, fr, f, lo);
    chk(f && fr == ref_frame(4'b1011, 12'hEEE, 12'h9C3), "R8 reset restores output",
        fr, ref_frame(4'b1011, 12'hEEE, 12'h9C3));
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL R3 watchdog actual=%0d expected=%0d", 190000, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_first_frames();
    t_divider();
    t_temp_mode();
    t_capture();
    t_overvolt();
    t_memfail();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule